// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Unit

This block is a shifter/rotator for an integer execution stage. It takes a 32-bit operand and a register-sourced count from 0 to 63, and performs one of four operations, left or right: arithmetic shift, logical shift, plain rotate, or rotate through the extend bit. The operation can work on the low byte, the low word or the whole long word. Bits of the operand above the selected size are passed to the result unchanged.

Along with the result, the unit produces five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). A combinational barrel core is built once for each operand size, and the selected size picks one of them. The result and the flags are captured in output registers, so a request presented in one cycle is answered after the next rising clock edge.

Top module: `shrot_unit`

## Requirements
- R1: A synchronous active-high reset clears the result and all five flags. After reset, the outputs for the inputs present at a rising edge appear after that edge and hold until the next edge.
- R2: The operation select encodes 2'b00 as arithmetic shift, 2'b01 as logical shift, 2'b10 as plain rotate and 2'b11 as rotate through extend. The direction input is 1 for left and 0 for right. A shift with a count of 0 returns the operand unchanged, clears C and V, and keeps X.
- R3: A left shift with a count below the size puts the last bit shifted out, which is operand bit (size − count), into both C and X. A left shift with a count at or above the size gives a zero result and clears C and X.
- R4: A right shift puts operand bit (count − 1) into both C and X. When the count is at or above the size, the result is filled with copies of the sign bit for an arithmetic shift and with zeros for a logical shift. When the count exceeds the size, C and X take the sign bit for an arithmetic shift and 0 for a logical shift.
- R5: V is always 0 for logical shifts and for arithmetic right shifts. An arithmetic left shift with a nonzero count sets V when the top bit of the result differs from the top bit of the original operand.
- R6: A plain rotate uses the count modulo the size and never changes X. With a reduced count of 0, C is cleared. Otherwise C is result bit 0 for a left rotate and the result's top bit for a right rotate.
- R7: A rotate through extend treats X as an extra bit above the operand and uses the count modulo (size + 1). With a reduced count of 0, X is kept and C is set equal to X. Otherwise C and X both take the last bit rotated out.
- R8: Both rotate forms clear V. For every operation, N is the top bit of the result at the selected size, and Z is 1 exactly when the result bits at the selected size are all zero.
- R9: The size select encodes 2'b00 as byte, 2'b01 as word and 2'b10 as long; 2'b11 is treated as long. Operand bits above the selected size appear in the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_i | input | 32 | Operand |
| count_i | input | 6 | Shift or rotate count, 0 to 63 |
| op_i | input | 2 | Operation select (see R2) |
| left_i | input | 1 | Direction: 1 left, 0 right |
| size_i | input | 2 | Operand size select (see R9) |
| x_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Registered result |
| x_o | output | 1 | Registered extend flag |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |
| v_o | output | 1 | Registered overflow flag |
| c_o | output | 1 | Registered carry flag |

## Verification
The result and every flag come from a single register stage, so each of them is due exactly one rising edge after the inputs are presented. The bench changes the inputs on a falling edge and reads the outputs on the following falling edge, with exactly one capture edge in between. A directed test checks that the outputs still show the previous answer just after new inputs arrive, and that they change only after the capture edge. Reset is checked in the same way: the outputs are read on the falling edge that follows the first reset edge.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [1:0] {
    OP_ASHIFT = 2'b00,
    OP_LSHIFT = 2'b01,
    OP_ROTATE = 2'b10,
    OP_ROTX   = 2'b11
  } shrot_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } shrot_size_e;

  localparam int NUM_SIZES = 3;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } shrot_flags_t;

endpackage

// File: rtl/shrot_shift.sv
// Shift core for one operand width (arithmetic or logical, either direction).
module shrot_shift #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     d,
  input  logic [CNT_W-1:0] cnt,
  input  logic             arith,
  input  logic             left,
  output logic [W-1:0]     res,
  output logic             c,
  output logic             v
);
  logic [W:0]        lx;
  logic signed [W:0] sx;
  logic signed [W:0] rx;
  logic              nz;

  always_comb begin
    nz = (cnt != '0);
    // Left: one spare bit above the operand catches the last bit shifted out.
    lx = {1'b0, d} << cnt;
    // Right: one spare bit below the operand catches the last bit shifted out.
    sx = {d, 1'b0};
    rx = arith ? (sx >>> cnt) : (sx >> cnt);
    if (left) begin
      res = lx[W-1:0];
      c   = nz && (int'(cnt) < W) ? lx[W] : 1'b0;
      v   = arith & nz & (d[W-1] ^ lx[W-1]);
    end else begin
      res = rx[W:1];
      c   = rx[0];
      v   = 1'b0;
    end
  end
endmodule

// File: rtl/shrot_rot.sv
// Plain rotate core for one operand width; count is taken modulo W.
module shrot_rot #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     d,
  input  logic [CNT_W-1:0] cnt,
  input  logic             left,
  output logic [W-1:0]     res,
  output logic             c
);
  localparam int EFF_W = $clog2(W);

  logic [EFF_W-1:0] eff;
  logic [EFF_W:0]   back;

  always_comb begin
    eff  = cnt[EFF_W-1:0];
    back = (EFF_W+1)'(W) - {1'b0, eff};
    if (left) res = (d << eff) | (d >> back);
    else      res = (d >> eff) | (d << back);
    if (eff == '0) c = 1'b0;
    else           c = left ? res[0] : res[W-1];
  end
endmodule

// File: rtl/shrot_xrot.sv
// Rotate-through-extend core: a ring of W+1 bits, count taken modulo W+1.
module shrot_xrot #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     d,
  input  logic [CNT_W-1:0] cnt,
  input  logic             x,
  input  logic             left,
  output logic [W-1:0]     res,
  output logic             c
);
  localparam int RW = W + 1;

  logic [CNT_W-1:0] eff;
  logic [CNT_W:0]   back;
  logic [RW-1:0]    ring;
  logic [RW-1:0]    turned;

  always_comb begin
    eff  = CNT_W'(int'(cnt) % RW);
    back = (CNT_W+1)'(RW) - {1'b0, eff};
    ring = {x, d};
    if (left) turned = (ring << eff) | (ring >> back);
    else      turned = (ring >> eff) | (ring << back);
    res = turned[W-1:0];
    // The ring's extra bit is the new extend; with eff == 0 it is still x.
    c   = turned[W];
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        op_i,
  input  logic              left_i,
  input  logic [1:0]        size_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] result_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int BYTE_W = DATA_W / 4;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    shrot_flags_t      flg;
  } lane_t;

  lane_t lane [NUM_SIZES];
  lane_t pick;
  shrot_op_e op;

  assign op = shrot_op_e'(op_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W = BYTE_W << g;

    logic [W-1:0] sh_res, ro_res, rx_res, r;
    logic         sh_c, sh_v, ro_c, rx_c;
    lane_t        ln;

    shrot_shift #(.W(W), .CNT_W(CNT_W)) u_shift (
      .d(opnd_i[W-1:0]), .cnt(count_i), .arith(op == OP_ASHIFT),
      .left(left_i), .res(sh_res), .c(sh_c), .v(sh_v)
    );

    shrot_rot #(.W(W), .CNT_W(CNT_W)) u_rot (
      .d(opnd_i[W-1:0]), .cnt(count_i), .left(left_i),
      .res(ro_res), .c(ro_c)
    );

    shrot_xrot #(.W(W), .CNT_W(CNT_W)) u_xrot (
      .d(opnd_i[W-1:0]), .cnt(count_i), .x(x_i), .left(left_i),
      .res(rx_res), .c(rx_c)
    );

    always_comb begin
      ln = '0;
      unique case (op)
        OP_ASHIFT, OP_LSHIFT: begin
          r        = sh_res;
          ln.flg.c = sh_c;
          ln.flg.v = sh_v;
          ln.flg.x = (count_i != '0) ? sh_c : x_i;
        end
        OP_ROTATE: begin
          r        = ro_res;
          ln.flg.c = ro_c;
          ln.flg.x = x_i;
        end
        default: begin
          r        = rx_res;
          ln.flg.c = rx_c;
          ln.flg.x = rx_c;
        end
      endcase
      ln.flg.n       = r[W-1];
      ln.flg.z       = (r == '0);
      ln.res         = opnd_i;
      ln.res[W-1:0]  = r;
    end

    assign lane[g] = ln;
  end

  always_comb begin
    unique case (shrot_size_e'(size_i))
      SZ_BYTE: pick = lane[0];
      SZ_WORD: pick = lane[1];
      default: pick = lane[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      x_o      <= 1'b0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
    end else begin
      result_o <= pick.res;
      x_o      <= pick.flg.x;
      n_o      <= pick.flg.n;
      z_o      <= pick.flg.z;
      v_o      <= pick.flg.v;
      c_o      <= pick.flg.c;
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [1:0]        op_i,
  input logic [1:0]        size_i,
  input logic              x_i,
  input logic [DATA_W-1:0] result_o,
  input logic              x_o,
  input logic              n_o,
  input logic              v_o,
  input logic              c_o
);
  localparam int BYTE_W = DATA_W / 4;

  // R2: zero-count shift leaves operand and X, clears C and V
  a_r2_zero_count_shift: assert property (@(posedge clk) disable iff (rst)
    (!op_i[1] && count_i == '0) |=>
      (!c_o && !v_o && x_o == $past(x_i) && result_o == $past(opnd_i)));

  // R5: logical shifts never report overflow
  a_r5_logical_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b01) |=> !v_o);

  // R6: plain rotate keeps X
  a_r6_rotate_keeps_x: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b10) |=> (x_o == $past(x_i)));

  // R7: rotate through extend leaves C equal to X
  a_r7_rotx_carry_is_x: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b11) |=> (c_o == x_o));

  // R8: rotates clear V
  a_r8_rotate_no_overflow: assert property (@(posedge clk) disable iff (rst)
    op_i[1] |=> !v_o);

  // R8: at long size N follows the result's top bit
  a_r8_long_negative: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b10) |=> (n_o == result_o[DATA_W-1]));

  // R9: byte operations pass upper operand bits through
  a_r9_byte_upper_pass: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b00) |=> (result_o[DATA_W-1:BYTE_W] == $past(opnd_i[DATA_W-1:BYTE_W])));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;
  localparam int DW = 32;
  localparam int NV = 24;
  // {req4, op2, dir1, size2, x1, count6, opnd32, res32, flags5 = x n z v c}
  localparam logic [84:0] VEC [NV] = '{
    {4'd3, 2'b00, 1'b1, 2'b00, 1'b0, 6'd1,  32'hAABBCC81, 32'hAABBCC02, 5'b10011}, // R3 R5 ASL byte
    {4'd3, 2'b01, 1'b1, 2'b00, 1'b1, 6'd8,  32'h000000FF, 32'h00000000, 5'b00100}, // R3 count==size
    {4'd3, 2'b01, 1'b1, 2'b01, 1'b1, 6'd4,  32'h12348765, 32'h12347650, 5'b00000}, // R3 word
    {4'd4, 2'b00, 1'b0, 2'b00, 1'b1, 6'd3,  32'h00000090, 32'h000000F2, 5'b01000}, // R4 ASR sign fill
    {4'd4, 2'b00, 1'b0, 2'b00, 1'b0, 6'd20, 32'h00000080, 32'h000000FF, 5'b11001}, // R4 count>size ASR
    {4'd4, 2'b01, 1'b0, 2'b01, 1'b0, 6'd16, 32'h00008001, 32'h00000000, 5'b10101}, // R4 count==size LSR
    {4'd4, 2'b01, 1'b0, 2'b10, 1'b1, 6'd40, 32'hFFFFFFFF, 32'h00000000, 5'b00100}, // R4 count>size LSR
    {4'd2, 2'b00, 1'b1, 2'b01, 1'b1, 6'd0,  32'h00008000, 32'h00008000, 5'b11000}, // R2 zero count
    {4'd2, 2'b00, 1'b0, 2'b10, 1'b0, 6'd0,  32'h00000000, 32'h00000000, 5'b00100}, // R2 zero count
    {4'd5, 2'b00, 1'b1, 2'b10, 1'b0, 6'd1,  32'h40000000, 32'h80000000, 5'b01010}, // R5 ASL overflow
    {4'd5, 2'b00, 1'b0, 2'b10, 1'b0, 6'd1,  32'h80000001, 32'hC0000000, 5'b11001}, // R5 ASR no V
    {4'd6, 2'b10, 1'b1, 2'b00, 1'b0, 6'd9,  32'h11223381, 32'h11223303, 5'b00001}, // R6 mod size
    {4'd6, 2'b10, 1'b0, 2'b01, 1'b1, 6'd16, 32'h00001234, 32'h00001234, 5'b10000}, // R6 eff zero
    {4'd8, 2'b10, 1'b0, 2'b01, 1'b0, 6'd4,  32'h0000ABCD, 32'h0000DABC, 5'b01001}, // R8 R6 ROR word
    {4'd6, 2'b10, 1'b1, 2'b10, 1'b1, 6'd63, 32'h00000002, 32'h00000001, 5'b10001}, // R6 long
    {4'd7, 2'b11, 1'b1, 2'b00, 1'b1, 6'd1,  32'h00000080, 32'h00000001, 5'b10001}, // R7 ROXL byte
    {4'd7, 2'b11, 1'b1, 2'b00, 1'b1, 6'd9,  32'h00000000, 32'h00000000, 5'b10101}, // R7 eff zero
    {4'd7, 2'b11, 1'b0, 2'b00, 1'b0, 6'd10, 32'h00000001, 32'h00000000, 5'b10101}, // R7 mod 9
    {4'd7, 2'b11, 1'b0, 2'b01, 1'b0, 6'd17, 32'h0000FFFF, 32'h0000FFFF, 5'b01000}, // R7 eff zero word
    {4'd7, 2'b11, 1'b1, 2'b10, 1'b0, 6'd34, 32'h80000000, 32'h00000000, 5'b10101}, // R7 mod 33
    {4'd7, 2'b11, 1'b0, 2'b10, 1'b1, 6'd33, 32'h00000005, 32'h00000005, 5'b10001}, // R7 eff zero long
    {4'd9, 2'b01, 1'b0, 2'b11, 1'b1, 6'd4,  32'hF0000000, 32'h0F000000, 5'b00000}, // R9 size 11 as long
    {4'd9, 2'b01, 1'b1, 2'b00, 1'b0, 6'd7,  32'hDEADBE01, 32'hDEADBE80, 5'b01000}, // R9 upper pass
    {4'd2, 2'b01, 1'b1, 2'b00, 1'b1, 6'd1,  32'h00000001, 32'h00000002, 5'b00000}  // R2 count one
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] opnd_i = '0;
  logic [5:0]    count_i = '0;
  logic [1:0]    op_i = '0;
  logic          left_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic          x_i = 1'b0;
  logic [DW-1:0] result_o;
  logic          x_o, n_o, z_o, v_o, c_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst(rst), .opnd_i(opnd_i), .count_i(count_i), .op_i(op_i),
    .left_i(left_i), .size_i(size_i), .x_i(x_i), .result_o(result_o),
    .x_o(x_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  task automatic check(string tag, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual res=%h flags=%b expected res=%h flags=%b",
               tag, act[36:5], act[4:0], exp[36:5], exp[4:0]);
    end
  endtask

  function automatic logic [36:0] outs();
    return {result_o, x_o, n_o, z_o, v_o, c_o};
  endfunction

  task automatic drive(logic [84:0] v);
    op_i    = v[80:79];
    left_i  = v[78];
    size_i  = v[77:76];
    x_i     = v[75];
    count_i = v[74:69];
    opnd_i  = v[68:37];
  endtask

  initial begin
    // R1: reset state with busy inputs
    drive(VEC[0]);
    @(negedge clk);
    check("R1 reset", outs(), 37'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][84:81], i), outs(), VEC[i][36:0]);
    end

    // R1: new inputs do not reach the outputs before the capture edge
    drive(VEC[3]);
    #1;
    check("R1 hold before edge", outs(), VEC[NV-1][36:0]);
    @(negedge clk);
    check("R1 update after edge", outs(), VEC[3][36:0]);

    // R1: reset in mid-run clears the outputs
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", outs(), 37'd0);
    rst = 1'b0;
    drive(VEC[9]);
    @(negedge clk);
    check("R5 after reset", outs(), VEC[9][36:0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule